// File: doc/BRIEF.md
# Staged Watchdog Controller with Disable Key

This block is a watchdog that software controls through four 32-bit registers. It watches one of several shared periodic timer lines. Each timer line is a one-cycle pulse input, and the source is chosen by a field in the configuration register. Each pulse on the chosen line that arrives without service moves an escalation stage forward:

- The first pulse sets a pending flag. The flag can raise a normal interrupt, a fast interrupt, or both.
- The second and third pulses hold the flag.
- The fourth pulse raises a reset request on whichever of two reset paths is enabled.

The reset request goes to an external reset generator.

Software starts and services the watchdog with a start command. Software sets the timer period to a quarter of the wanted watchdog period, so that the four-step escalation spans the whole period. Stopping the watchdog needs two steps: a key must first be written to the unlock register, and only then is a disable command accepted. A write to any other register between the two steps cancels the key.

Software picks the timer for watchdog n as (7 + n) mod 10. The block itself accepts any index below the number of timer lines.

Top module: `wdog_stage_ctrl`

## Requirements
- R1: After reset all register state is zero, every output is low, and reads of the configuration (0x0) and status (0x4) registers return 0.
- R2: Configuration register 0x0 keeps only these bits: source index [3:0], periodic bit 4, interrupt enable bit 12, fast interrupt enable bit 13, direct reset enable bit 14, power-path reset enable bit 15. Reading it returns exactly the kept bits, so writing all ones reads back 0x0000F01F.
- R3: Only pulses on the timer line whose index equals the source field advance the stage. Pulses on other lines have no effect. A source index at or above the number of lines never counts.
- R4: The first counted pulse sets status bit 1 (pending). It drives irq_o high if bit 12 is set and fiq_o high if bit 13 is set, from the clock edge that samples the pulse.
- R5: The second and third counted pulses assert no reset. The fourth raises rst_sys_o if bit 14 is set and rst_pmc_o if bit 15 is set. The requests stay high until a start, an accepted disable, or block reset.
- R6: Writing bit 0 of command register 0x8 sets status bit 0 (running). In the same write cycle it clears the stage, the pending bit and both reset requests. A start takes priority over a disable bit in the same write.
- R7: Writing bit 1 of the command register while no key is held is ignored. The watchdog keeps running and keeps counting.
- R8: Writing 0x0000C45A to unlock register 0xC and then writing command bit 1 stops the watchdog. It clears the running, pending and stage state. While stopped, timer pulses are ignored and all outputs stay low.
- R9: The held key is cleared by any write to register 0x0, 0x4 or 0xC other than the key itself. It is also cleared by one disable command, so a second disable needs a fresh key.
- R10: With periodic bit 4 clear, only the first pulse after a start is counted. Pending is set, and no reset follows however many pulses arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset; 0x0 config, 0x4 status, 0x8 command, 0xC unlock |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_i | input | NTMR | Expiry pulses of the shared periodic timers |
| irq_o | output | 1 | Normal interrupt |
| fiq_o | output | 1 | Fast interrupt |
| rst_sys_o | output | 1 | Reset request on the direct path |
| rst_pmc_o | output | 1 | Reset request on the power-management path |

## Verification
The hardest state to reach is a held key that a single stray write has silently dropped. Such a drop makes a later disable fail with no visible sign. The stimulus writes the key, then a configuration write, then a disable, and checks at the running bit and the counting that the watchdog still works. It then unlocks and disables twice in a row to show that the key is spent. Escalation is driven to its fourth step on both reset paths. A start is inserted at the third step to show that the count begins again from zero.

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl #(
  parameter int NTMR = 11,
  parameter int SELW = 4,
  parameter logic [31:0] KEY = 32'h0000_C45A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NTMR-1:0]  tick_i,
  output logic             irq_o,
  output logic             fiq_o,
  output logic             rst_sys_o,
  output logic             rst_pmc_o
);
  logic [SELW-1:0] src;
  logic periodic, irq_en, fiq_en, sys_en, pmc_en;
  logic running, pending, fired, unlocked;
  logic [1:0] stage;
  logic hit, counted;

  wire aligned = reg_addr[1:0] == 2'b00;
  wire wr_cfg  = reg_wr && aligned && reg_addr[3:2] == 2'd0;
  wire wr_cmd  = reg_wr && aligned && reg_addr[3:2] == 2'd2;
  wire wr_key  = reg_wr && aligned && reg_addr[3:2] == 2'd3;
  wire do_start = wr_cmd && reg_wdata[0];
  wire do_stop  = wr_cmd && !reg_wdata[0] && reg_wdata[1] && unlocked;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NTMR; i++)
      if (src == SELW'(i)) hit = tick_i[i];
  end

  assign counted = running && hit && (periodic || stage == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0; periodic <= 1'b0; irq_en <= 1'b0; fiq_en <= 1'b0;
      sys_en <= 1'b0; pmc_en <= 1'b0;
    end else if (wr_cfg) begin
      src <= reg_wdata[SELW-1:0];
      periodic <= reg_wdata[4];
      irq_en <= reg_wdata[12];
      fiq_en <= reg_wdata[13];
      sys_en <= reg_wdata[14];
      pmc_en <= reg_wdata[15];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; pending <= 1'b0; fired <= 1'b0; stage <= 2'd0;
    end else if (do_start) begin
      running <= 1'b1; pending <= 1'b0; fired <= 1'b0; stage <= 2'd0;
    end else if (do_stop) begin
      running <= 1'b0; pending <= 1'b0; fired <= 1'b0; stage <= 2'd0;
    end else if (counted) begin
      pending <= 1'b1;
      if (stage == 2'd3) fired <= 1'b1;
      else stage <= stage + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (wr_key && reg_wdata == KEY) unlocked <= 1'b1;
    else if (wr_cmd) begin
      if (reg_wdata[1]) unlocked <= 1'b0;
    end else if (reg_wr) unlocked <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (reg_addr[3:2])
        2'd0: begin
          reg_rdata[SELW-1:0] = src;
          reg_rdata[4]  = periodic;
          reg_rdata[12] = irq_en;
          reg_rdata[13] = fiq_en;
          reg_rdata[14] = sys_en;
          reg_rdata[15] = pmc_en;
        end
        2'd1: reg_rdata[1:0] = {pending, running};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq_o     = running && pending && irq_en;
  assign fiq_o     = running && pending && fiq_en;
  assign rst_sys_o = running && fired && sys_en;
  assign rst_pmc_o = running && fired && pmc_en;

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> (running && !pending && stage == 2'd0 && !rst_sys_o && !rst_pmc_o));
  a_r5_fire_after_third: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired) |-> $past(stage) == 2'd3);
  a_r8_stopped_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !do_start) |=> (!running && stage == 2'd0 && !pending));
  a_r7_locked_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_cmd && !reg_wdata[0] && !unlocked) |=> running);
  a_r4_first_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hit && stage == 2'd0 && !wr_cmd) |=> pending);
  a_r9_key_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[1]) |=> !unlocked);
endmodule

// File: tb/wdog_stage_ctrl_test.sv
module wdog_stage_ctrl_test;
  localparam int NTMR = 11;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NTMR-1:0] tick_i = '0;
  logic irq_o, fiq_o, rst_sys_o, rst_pmc_o;
  int total = 0, bad = 0;

  wdog_stage_ctrl #(.NTMR(NTMR)) uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .tick_i, .irq_o, .fiq_o, .rst_sys_o, .rst_pmc_o);

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse(int n);
    @(negedge clk); tick_i = '0; tick_i[n] = 1'b1;
    @(negedge clk); tick_i = '0;
  endtask

  function automatic logic [3:0] outs();
    return {irq_o, fiq_o, rst_sys_o, rst_pmc_o};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 cfg", d, 0);
    rd(4'h4, d); chk("R1 status", d, 0);
    chk("R1 outputs", outs(), 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk("R2 mask", d, 32'h0000_F01F);
    wr(4'h0, 32'h0000_5017); rd(4'h0, d); chk("R2 readback", d, 32'h0000_5017);
  endtask

  task automatic t_escalate();
    logic [31:0] d;
    wr(4'h0, 32'h0000_5017); wr(4'h8, 1);
    rd(4'h4, d); chk("R6 running", d, 32'h1);
    pulse(7); rd(4'h4, d); chk("R4 pending", d, 32'h3);
    chk("R4 irq only", outs(), 4'b1000);
    pulse(7); pulse(7); chk("R5 no reset at 3", outs(), 4'b1000);
    pulse(7); chk("R5 sys reset at 4", outs(), 4'b1010);
    pulse(7); chk("R5 reset holds", outs(), 4'b1010);
    wr(4'h8, 1); rd(4'h4, d); chk("R6 start clears", d, 32'h1);
    chk("R6 outputs cleared", outs(), 0);
  endtask

  task automatic t_fiq_pmc();
    wr(4'h0, 32'h0000_A01A); wr(4'h8, 1);
    pulse(10); chk("R4 fiq only", outs(), 4'b0100);
    pulse(10); pulse(10); pulse(10); chk("R5 pmc reset", outs(), 4'b0101);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(4'h0, 32'h0000_5018); wr(4'h8, 1);
    pulse(7); pulse(0); pulse(9);
    rd(4'h4, d); chk("R3 other lines ignored", d, 32'h1);
    pulse(8); rd(4'h4, d); chk("R3 chosen line counts", d, 32'h3);
    wr(4'h0, 32'h0000_501C); wr(4'h8, 1);
    for (int i = 0; i < NTMR; i++) pulse(i);
    rd(4'h4, d); chk("R3 index out of range", d, 32'h1);
  endtask

  task automatic t_service();
    wr(4'h0, 32'h0000_5017); wr(4'h8, 1);
    pulse(7); pulse(7); pulse(7);
    wr(4'h8, 3); chk("R6 start beats disable", outs(), 0);
    pulse(7); pulse(7); pulse(7); chk("R6 count restarted", outs(), 4'b1000);
    pulse(7); chk("R5 reset after restart", outs(), 4'b1010);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(4'h0, 32'h0000_5017); wr(4'h8, 1);
    wr(4'h8, 2); rd(4'h4, d); chk("R7 disable without key", d, 32'h1);
    pulse(7); rd(4'h4, d); chk("R7 still counting", d, 32'h3);
    wr(4'hC, 32'h0000_C45B); wr(4'h8, 2); rd(4'h4, d); chk("R9 wrong key", d, 32'h3);
    wr(4'hC, 32'h0000_C45A); wr(4'h0, 32'h0000_5017); wr(4'h8, 2);
    rd(4'h4, d); chk("R9 cfg write drops key", d, 32'h3);
    wr(4'hC, 32'h0000_C45A); wr(4'h4, 0); wr(4'h8, 2);
    rd(4'h4, d); chk("R9 status write drops key", d, 32'h3);
    wr(4'hC, 32'h0000_C45A); wr(4'h8, 2);
    rd(4'h4, d); chk("R8 disabled", d, 0);
    chk("R8 outputs low", outs(), 0);
    for (int i = 0; i < 5; i++) pulse(7);
    rd(4'h4, d); chk("R8 pulses ignored", d, 0);
    chk("R8 no reset while stopped", outs(), 0);
    wr(4'h8, 1); wr(4'h8, 2); rd(4'h4, d); chk("R9 key spent", d, 32'h1);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(4'h0, 32'h0000_5007); wr(4'h8, 1);
    for (int i = 0; i < 6; i++) pulse(7);
    rd(4'h4, d); chk("R10 pending", d, 32'h3);
    chk("R10 no reset", outs(), 4'b1000);
  endtask

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_cfg(); t_escalate(); t_fiq_pmc(); t_select();
    t_service(); t_lock(); t_oneshot();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule